// File: doc/BRIEF.md
# Four-Channel Interval Timer

This block holds four separate 32-bit down-counters behind a simple register bus. The bus has an address, write data and a write strobe, and read data that follows the address combinationally. Software programs each channel through its own 64-byte register window. It sets a start value, picks a repeat or stop-once behaviour, and starts, stops or restarts the count. Each channel raises its own interrupt line when its count runs out. A shared status word shows every channel's pending flag at once.

Each channel has two small state machines. The counter machine has the states CNT_IDLE, CNT_COUNT and CNT_RELOAD. A start write moves any state to CNT_COUNT. A stop write moves any state to CNT_IDLE. A timeout in CNT_COUNT moves to CNT_RELOAD in repeat mode and to CNT_IDLE in stop-once mode. CNT_RELOAD always returns to CNT_COUNT. The clear machine has the states CLR_READY, CLR_BUSY1 and CLR_BUSY2. An accepted clear moves CLR_READY to CLR_BUSY1. The machine then always steps to CLR_BUSY2 and back to CLR_READY. While it is away from CLR_READY, a busy flag is visible and further clear requests are dropped.

Top module: `mtm_top`

## Requirements
- R1: After reset every count, start value, mode bit, enable, mask and pending flag is 0, and all interrupt outputs are low.
- R2: Channel n's window starts at address n×0x40. Within a window the offsets are: 0x04 mode (bit 0), 0x08 start value, 0x10 enable (bit 0), 0x14 restart (reads 0), 0x18 current count (read-only), 0x20 clear/pending (bit 0 pending, bit 1 busy) and 0x24 mask (bit 0). Offset 0x00 of any window reads the shared status, which holds channel n's pending flag in bit n.
- R3: Writing 1 to enable copies the start value into the count on that edge. The count then drops by one on each following clock edge.
- R4: When a running count goes from 1 to 0, the pending flag is set on the same edge. A start value of 0 times out on the first edge after starting.
- R5: With mode bit 0 (repeat), the count reloads the start value on the edge after a timeout and keeps running, so timeouts come every start value + 1 cycles.
- R6: With mode bit 1 (stop once), enable reads 0 after the timeout and the count stays at 0.
- R7: Writing 0 to enable stops the channel on that edge, and the count keeps its value. The write takes priority over the decrement in the same cycle.
- R8: A write of any data to the restart offset copies the start value into the count. This works whether the channel is running or stopped, and it leaves enable unchanged.
- R9: Writing 1 to clear bit 0 while not busy clears the pending flag on that edge and raises busy for exactly 2 cycles. Writing 0 to that bit has no effect.
- R10: Clear writes made while busy is 1 are ignored.
- R11: If a timeout and an accepted clear fall on the same edge, the pending flag stays set and busy still starts.
- R12: With mask 1 the channel's interrupt output is low, while the pending flag is still recorded and readable. With mask 0 the interrupt output follows the pending flag.
- R13: Activity on one channel does not change another channel's count or pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address: channel in [7:6], offset in [5:0] |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 4 | Per-channel interrupt, pending and not masked |

## Verification
The bench issues a clear on the very edge on which a stop-once count expires. A design that let the clear win would lose that interrupt and read pending as 0. It then retries the clear during the two busy cycles. A design with a shorter busy window, or one that ignored busy, would clear the flag too early. Restarts written with data 0 and with an arbitrary pattern show whether a design decodes the data bit instead of the write itself. A stop written in a running cycle shows whether the count slips by one. A start value of 0 and an interrupt that is masked while pending probe the edges of the timeout and gating logic. A repeat channel is watched over two periods to catch an off-by-one in the reload step.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
    localparam int DATA_W   = 32;
    localparam int WIN_BITS = 6;

    localparam logic [WIN_BITS-1:0] OFS_STATUS = 6'h00;
    localparam logic [WIN_BITS-1:0] OFS_MODE   = 6'h04;
    localparam logic [WIN_BITS-1:0] OFS_START  = 6'h08;
    localparam logic [WIN_BITS-1:0] OFS_ENABLE = 6'h10;
    localparam logic [WIN_BITS-1:0] OFS_RESTRT = 6'h14;
    localparam logic [WIN_BITS-1:0] OFS_COUNT  = 6'h18;
    localparam logic [WIN_BITS-1:0] OFS_CLEAR  = 6'h20;
    localparam logic [WIN_BITS-1:0] OFS_MASK   = 6'h24;

    typedef enum logic [1:0] {
        CNT_IDLE,
        CNT_COUNT,
        CNT_RELOAD
    } cnt_state_e;

    typedef enum logic [1:0] {
        CLR_READY,
        CLR_BUSY1,
        CLR_BUSY2
    } clr_state_e;

    typedef struct packed {
        logic mode;
        logic start;
        logic enable;
        logic restart;
        logic clear;
        logic mask;
    } ch_wr_t;
endpackage

// File: rtl/mtm_regdec.sv
module mtm_regdec import mtm_pkg::*; #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    localparam int CH_BITS = $clog2(NUM_CH),
    localparam int ADDR_W  = CH_BITS + WIN_BITS
) (
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [NUM_CH-1:0]             ch_mode,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  ch_start,
    input  logic [NUM_CH-1:0]             ch_en,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt,
    input  logic [NUM_CH-1:0]             ch_pend,
    input  logic [NUM_CH-1:0]             ch_busy,
    input  logic [NUM_CH-1:0]             ch_mask,
    output ch_wr_t [NUM_CH-1:0]           ch_wr,
    output logic [DATA_W-1:0]             bus_rdata
);
    logic [CH_BITS-1:0]  sel;
    logic [WIN_BITS-1:0] ofs;

    assign sel = bus_addr[ADDR_W-1:WIN_BITS];
    assign ofs = bus_addr[WIN_BITS-1:0];

    // One write strobe per channel register
    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_wr
            always_comb begin
                ch_wr[g] = '0;
                if (bus_we && (sel == CH_BITS'(g))) begin
                    unique case (ofs)
                        OFS_MODE:   ch_wr[g].mode    = 1'b1;
                        OFS_START:  ch_wr[g].start   = 1'b1;
                        OFS_ENABLE: ch_wr[g].enable  = 1'b1;
                        OFS_RESTRT: ch_wr[g].restart = 1'b1;
                        OFS_CLEAR:  ch_wr[g].clear   = 1'b1;
                        OFS_MASK:   ch_wr[g].mask    = 1'b1;
                        default:    ch_wr[g]         = '0;
                    endcase
                end
            end
        end
    endgenerate

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (ofs)
            OFS_STATUS: bus_rdata = DATA_W'(ch_pend);
            OFS_MODE:   bus_rdata = DATA_W'(ch_mode[sel]);
            OFS_START:  bus_rdata = DATA_W'(ch_start[sel]);
            OFS_ENABLE: bus_rdata = DATA_W'(ch_en[sel]);
            OFS_COUNT:  bus_rdata = DATA_W'(ch_cnt[sel]);
            OFS_CLEAR:  bus_rdata = DATA_W'({ch_busy[sel], ch_pend[sel]});
            OFS_MASK:   bus_rdata = DATA_W'(ch_mask[sel]);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mtm_channel.sv
module mtm_channel import mtm_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ch_wr_t            wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              mode_o,
    output logic [CNT_W-1:0]  start_o,
    output logic              en_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              pend_o,
    output logic              busy_o,
    output logic              mask_o
);
    cnt_state_e cst_q, cst_d;
    clr_state_e kst_q, kst_d;

    logic             mode_q;
    logic             mask_q;
    logic             pend_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] cnt_q;

    logic go_w, halt_w, expire_w, clr_go_w;

    assign go_w     = wr_i.enable & wdata_i[0];
    assign halt_w   = wr_i.enable & ~wdata_i[0];
    assign expire_w = (cst_q == CNT_COUNT) && (cnt_q <= CNT_W'(1))
                      && !wr_i.enable && !wr_i.restart;
    assign clr_go_w = wr_i.clear && wdata_i[0] && (kst_q == CLR_READY);

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cst_q <= CNT_IDLE;
            kst_q <= CLR_READY;
        end else begin
            cst_q <= cst_d;
            kst_q <= kst_d;
        end
    end

    // Counter next state
    always_comb begin
        cst_d = cst_q;
        unique case (cst_q)
            CNT_IDLE: begin
                if (go_w) cst_d = CNT_COUNT;
            end
            CNT_COUNT: begin
                if (halt_w)        cst_d = CNT_IDLE;
                else if (go_w)     cst_d = CNT_COUNT;
                else if (expire_w) cst_d = mode_q ? CNT_IDLE : CNT_RELOAD;
            end
            CNT_RELOAD: begin
                if (halt_w) cst_d = CNT_IDLE;
                else        cst_d = CNT_COUNT;
            end
            default: cst_d = CNT_IDLE;
        endcase
    end

    // Clear handshake next state
    always_comb begin
        kst_d = kst_q;
        unique case (kst_q)
            CLR_READY: if (clr_go_w) kst_d = CLR_BUSY1;
            CLR_BUSY1: kst_d = CLR_BUSY2;
            CLR_BUSY2: kst_d = CLR_READY;
            default:   kst_d = CLR_READY;
        endcase
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            mask_q  <= 1'b0;
            start_q <= '0;
        end else begin
            if (wr_i.mode)  mode_q  <= wdata_i[0];
            if (wr_i.mask)  mask_q  <= wdata_i[0];
            if (wr_i.start) start_q <= wdata_i[CNT_W-1:0];
        end
    end

    // Count and pending datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (go_w) begin
                cnt_q <= start_q;
            end else if (halt_w) begin
                cnt_q <= cnt_q;
            end else if (wr_i.restart) begin
                cnt_q <= start_q;
            end else begin
                unique case (cst_q)
                    CNT_COUNT:  cnt_q <= expire_w ? '0 : cnt_q - CNT_W'(1);
                    CNT_RELOAD: cnt_q <= start_q;
                    default:    cnt_q <= cnt_q;
                endcase
            end

            if (expire_w)      pend_q <= 1'b1;
            else if (clr_go_w) pend_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        mode_o  = mode_q;
        start_o = start_q;
        en_o    = (cst_q != CNT_IDLE);
        cnt_o   = cnt_q;
        pend_o  = pend_q;
        busy_o  = (kst_q != CLR_READY);
        mask_o  = mask_q;
    end
endmodule

// File: rtl/mtm_top.sv
module mtm_top import mtm_pkg::*; #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    localparam int ADDR_W = $clog2(NUM_CH) + WIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    ch_wr_t [NUM_CH-1:0]            ch_wr;
    logic [NUM_CH-1:0]              ch_mode;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_start;
    logic [NUM_CH-1:0]              ch_en;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_cnt;
    logic [NUM_CH-1:0]              ch_pend;
    logic [NUM_CH-1:0]              ch_busy;
    logic [NUM_CH-1:0]              ch_mask;

    mtm_regdec #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .ch_mode  (ch_mode),
        .ch_start (ch_start),
        .ch_en    (ch_en),
        .ch_cnt   (ch_cnt),
        .ch_pend  (ch_pend),
        .ch_busy  (ch_busy),
        .ch_mask  (ch_mask),
        .ch_wr    (ch_wr),
        .bus_rdata(bus_rdata)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            mtm_channel #(.CNT_W(CNT_W)) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_i   (ch_wr[g]),
                .wdata_i(bus_wdata),
                .mode_o (ch_mode[g]),
                .start_o(ch_start[g]),
                .en_o   (ch_en[g]),
                .cnt_o  (ch_cnt[g]),
                .pend_o (ch_pend[g]),
                .busy_o (ch_busy[g]),
                .mask_o (ch_mask[g])
            );
            assign irq[g] = ch_pend[g] & ~ch_mask[g];
        end
    endgenerate
endmodule

// File: rtl/mtm_checker.sv
module mtm_checker #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_we,
    input logic [NUM_CH-1:0]            irq,
    input logic [NUM_CH-1:0]            ch_en,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0]            ch_pend,
    input logic [NUM_CH-1:0]            ch_busy,
    input logic [NUM_CH-1:0]            ch_mask
);
    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
            p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
                ch_en[g] && (ch_cnt[g] > CNT_W'(1)) && !bus_we
                |=> ch_cnt[g] == $past(ch_cnt[g]) - CNT_W'(1));

            p_timeout_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ch_en[g] && (ch_cnt[g] == CNT_W'(1)) && !bus_we |=> ch_pend[g]);

            p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_en[g] && !bus_we |=> $stable(ch_cnt[g]));

            p_busy_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ch_busy[g]) |=> ch_busy[g]);

            p_busy_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
                ch_busy[g] && $past(ch_busy[g]) |=> !ch_busy[g]);

            p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
                ch_pend[g] && !bus_we |=> ch_pend[g]);

            p_mask_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
                ch_mask[g] |-> !irq[g]);
        end
    endgenerate
endmodule

bind mtm_top mtm_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_mtm_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_we (bus_we),
    .irq    (irq),
    .ch_en  (ch_en),
    .ch_cnt (ch_cnt),
    .ch_pend(ch_pend),
    .ch_busy(ch_busy),
    .ch_mask(ch_mask)
);

// File: tb/mtm_top_test.sv
`timescale 1ns/1ps
module mtm_top_test;
    localparam logic [5:0] O_STAT = 6'h00, O_MODE = 6'h04, O_START = 6'h08,
                           O_EN = 6'h10, O_RST = 6'h14, O_CNT = 6'h18,
                           O_CLR = 6'h20, O_MASK = 6'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    bit          fin = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    mtm_top uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        bit          is_irq;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  mon_done;

    function automatic logic [7:0] ra(input int ch, input logic [5:0] ofs);
        return {2'(ch), ofs};
    endfunction

    // Monitor: pops expected items and compares with the design's output
    initial begin : monitor
        item_t       it;
        logic [31:0] act;
        forever begin
            while (sb_q.size() == 0) #0.05;
            it = sb_q.pop_front();
            if (!it.is_irq) bus_addr = it.addr;
            #0.2;
            act = it.is_irq ? {28'b0, irq} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
            -> mon_done;
        end
    end

    task automatic exp_rd(input int ch, input logic [5:0] ofs,
                          input logic [31:0] e, input string tag);
        item_t it;
        it.addr = ra(ch, ofs); it.exp = e; it.is_irq = 1'b0; it.tag = tag;
        sb_q.push_back(it);
        @(mon_done);
    endtask

    task automatic exp_irq(input logic [3:0] e, input string tag);
        item_t it;
        it.addr = '0; it.exp = {28'b0, e}; it.is_irq = 1'b1; it.tag = tag;
        sb_q.push_back(it);
        @(mon_done);
    endtask

    task automatic wr(input int ch, input logic [5:0] ofs, input logic [31:0] d);
        bus_addr  = ra(ch, ofs);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin : watchdog
        #(100000 * 5);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        exp_rd(0, O_STAT, 32'h0, "R1 status");
        exp_rd(0, O_CNT, 32'h0, "R1 count");
        exp_rd(1, O_MODE, 32'h0, "R1 mode");
        exp_rd(2, O_EN, 32'h0, "R1 enable");
        @(negedge clk);
        exp_rd(3, O_MASK, 32'h0, "R1 mask");
        exp_rd(3, O_START, 32'h0, "R1 start");
        exp_irq(4'h0, "R1 irq");

        // R3 R4 R6 stop-once countdown on channel 0
        wr(0, O_MODE, 32'h1);
        wr(0, O_START, 32'd5);
        wr(0, O_EN, 32'h1);
        exp_rd(0, O_CNT, 32'd5, "R3 loaded on enable");
        repeat (2) @(negedge clk);
        exp_rd(0, O_CNT, 32'd3, "R3 decrement");
        repeat (2) @(negedge clk);
        exp_rd(0, O_CNT, 32'd1, "R3 count one");
        exp_rd(0, O_CLR, 32'h0, "R4 not yet pending");
        @(negedge clk);
        exp_rd(0, O_CNT, 32'd0, "R4 count zero");
        exp_rd(0, O_CLR, 32'h1, "R4 pending set");
        exp_rd(0, O_EN, 32'h0, "R6 enable dropped");
        exp_irq(4'h1, "R12 irq follows pending");
        @(negedge clk);
        exp_rd(0, O_STAT, 32'h1, "R2 status bit0");
        repeat (3) @(negedge clk);
        exp_rd(0, O_CNT, 32'd0, "R6 count holds zero");

        // R9 clear handshake
        wr(0, O_CLR, 32'h0);
        exp_rd(0, O_CLR, 32'h1, "R9 write 0 no effect");
        wr(0, O_CLR, 32'h1);
        exp_rd(0, O_CLR, 32'h2, "R9 cleared and busy");
        @(negedge clk);
        exp_rd(0, O_CLR, 32'h2, "R9 busy second cycle");
        @(negedge clk);
        exp_rd(0, O_CLR, 32'h0, "R9 busy dropped");
        exp_irq(4'h0, "R9 irq low after clear");

        // R11 R10 timeout and clear on the same edge
        wr(0, O_START, 32'd4);
        wr(0, O_EN, 32'h1);
        repeat (3) @(negedge clk);
        wr(0, O_CLR, 32'h1);
        exp_rd(0, O_CLR, 32'h3, "R11 timeout beats clear");
        wr(0, O_CLR, 32'h1);
        exp_rd(0, O_CLR, 32'h3, "R10 clear ignored while busy");
        @(negedge clk);
        exp_rd(0, O_CLR, 32'h1, "R10 busy ended pending kept");
        wr(0, O_CLR, 32'h1);
        exp_rd(0, O_CLR, 32'h2, "R9 clear after busy");
        repeat (2) @(negedge clk);

        // R12 mask
        wr(0, O_MASK, 32'h1);
        wr(0, O_START, 32'd1);
        wr(0, O_EN, 32'h1);
        @(negedge clk);
        exp_irq(4'h0, "R12 masked irq low");
        exp_rd(0, O_STAT, 32'h1, "R12 pending still recorded");
        wr(0, O_MASK, 32'h0);
        exp_irq(4'h1, "R12 unmasked irq high");
        wr(0, O_CLR, 32'h1);
        repeat (2) @(negedge clk);

        // R4 start value of zero
        wr(0, O_START, 32'd0);
        wr(0, O_EN, 32'h1);
        exp_rd(0, O_EN, 32'h1, "R4 zero start running");
        @(negedge clk);
        exp_rd(0, O_CLR, 32'h1, "R4 zero start times out");
        exp_rd(0, O_EN, 32'h0, "R6 zero start stops");
        wr(0, O_CLR, 32'h1);
        repeat (2) @(negedge clk);

        // R5 repeat mode on channel 1
        wr(1, O_MODE, 32'h0);
        wr(1, O_START, 32'd3);
        wr(1, O_EN, 32'h1);
        exp_rd(1, O_CNT, 32'd3, "R5 loaded");
        repeat (3) @(negedge clk);
        exp_rd(1, O_CNT, 32'd0, "R5 first timeout");
        exp_rd(1, O_CLR, 32'h1, "R5 pending");
        @(negedge clk);
        exp_rd(1, O_CNT, 32'd3, "R5 reloaded");
        exp_rd(1, O_EN, 32'h1, "R5 still enabled");
        repeat (3) @(negedge clk);
        exp_rd(1, O_CNT, 32'd0, "R5 second timeout");
        exp_rd(2, O_STAT, 32'h2, "R13 status only channel 1");
        exp_rd(0, O_CNT, 32'd0, "R13 channel 0 untouched");
        wr(1, O_EN, 32'h0);
        wr(1, O_CLR, 32'h1);
        repeat (2) @(negedge clk);

        // R8 restart with arbitrary data, R7 stop priority on channel 2
        wr(2, O_MODE, 32'h1);
        wr(2, O_START, 32'd100);
        wr(2, O_EN, 32'h1);
        repeat (10) @(negedge clk);
        exp_rd(2, O_CNT, 32'd90, "R3 ten cycles");
        wr(2, O_RST, 32'h0);
        exp_rd(2, O_CNT, 32'd100, "R8 restart data 0");
        repeat (5) @(negedge clk);
        exp_rd(2, O_CNT, 32'd95, "R8 counting after restart");
        wr(2, O_RST, 32'hDEAD_BEEF);
        exp_rd(2, O_CNT, 32'd100, "R8 restart other data");
        exp_rd(2, O_EN, 32'h1, "R8 enable unchanged");
        wr(2, O_EN, 32'h0);
        exp_rd(2, O_CNT, 32'd100, "R7 stop beats decrement");
        wr(2, O_START, 32'd7);
        wr(2, O_RST, 32'h1);
        exp_rd(2, O_CNT, 32'd7, "R8 restart while stopped");
        exp_rd(2, O_EN, 32'h0, "R8 stays stopped");
        repeat (3) @(negedge clk);
        exp_rd(2, O_CNT, 32'd7, "R7 idle holds");
        exp_rd(2, O_START, 32'd7, "R2 start readback");

        // R7 stop mid-count on channel 3
        wr(3, O_MODE, 32'h1);
        wr(3, O_START, 32'd50);
        wr(3, O_EN, 32'h1);
        repeat (5) @(negedge clk);
        exp_rd(3, O_CNT, 32'd45, "R3 channel 3 count");
        wr(3, O_EN, 32'h0);
        exp_rd(3, O_CNT, 32'd45, "R7 stopped value");
        repeat (4) @(negedge clk);
        exp_rd(3, O_CNT, 32'd45, "R7 held value");
        exp_rd(3, O_RST, 32'h0, "R2 restart reads zero");
        exp_rd(3, O_STAT, 32'h0, "R13 no pending anywhere");
        exp_irq(4'h0, "R12 all irq low");

        fin = 1'b1;
        summary();
        $finish;
    end
endmodule